// File: doc/BRIEF.md
# Autoinit DMA Channel Transfer Engine

This block sequences the byte addresses for one channel of a DMA controller. A client asks for N bytes. The engine then emits N physical byte addresses, one per clock and with no gaps. Each address joins an 8-bit page (bits 23:16) to a 16-bit running offset (bits 15:0). The engine does not move any data itself. It only produces the address stream and tracks how many bytes are left in the programmed buffer.

The channel is programmed through base offset, base count and page inputs. A one-cycle touch strobe marks that any of these has been rewritten. The programmed transfer length is the base count plus one. The engine picks up new settings lazily: it loads the running offset and the remaining count from the base values only when the first active request after a touch is accepted.

The channel always runs in autoinit fashion. If the remaining count reaches zero partway through a request, the engine reloads the offset, count and page from the base values and serves the rest of that same request from the start of the buffer. A masked channel, or a request of zero bytes, completes at once with a moved count of zero.

Top module: `autoinit_dma_engine`

## Requirements
- R1: After reset the engine is idle: `req_ready`=1, `beat_valid`=0, `done`=0, `cur_ofs`=0, `cur_cnt`=0. The reprogrammed state is pending, so the first active request loads the base values.
- R2: Each beat address is formed as `beat_addr[23:16]` = page and `beat_addr[15:0]` = offset.
- R3: When an active request is accepted while reprogramming is pending, the engine loads offset = `cfg_base_ofs`, count = `cfg_base_cnt`+1 (17 bits, so a base count of 0xFFFF gives 0x10000) and the page, and clears the pending state. Requests that are not preceded by a touch continue from the current offset and count.
- R4: A request accepted while `cfg_mask`=1, or with `req_len`=0, produces no beat. It raises `done` in the next cycle with `done_count`=0 and leaves `cur_ofs`, `cur_cnt` and the pending state unchanged.
- R5: An accepted request of N>0 bytes produces exactly N beats on consecutive cycles, starting the cycle after acceptance. Each beat taken while the count is nonzero uses the current offset, then increments the offset by one and decrements the count by one.
- R6: A beat that is needed while the count is zero first reloads from the base values and page. That beat uses address {page, base offset}, after which the offset is base+1 and the count is base count. The request continues with no gap.
- R7: `done` is high for one cycle, in the cycle after the last beat, with `done_count` equal to the number of beats. `req_ready` is high only while idle, and a request presented while busy is ignored.
- R8: The offset wraps from 0xFFFF to 0x0000 without changing the page bits.
- R9: A touch that arrives during a transfer does not change the running offset of that transfer. The new base values are loaded at the next accepted active request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base_ofs | input | 16 | Programmed start offset |
| cfg_base_cnt | input | 16 | Programmed count (length minus one) |
| cfg_page | input | 8 | Programmed page, address bits 23:16 |
| cfg_mask | input | 1 | Channel masked |
| cfg_touch | input | 1 | One-cycle strobe: base values were rewritten |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_len | input | 16 | Number of bytes requested |
| req_ready | output | 1 | Engine idle and able to accept a request |
| beat_valid | output | 1 | A byte address is presented this cycle |
| beat_addr | output | 24 | Physical byte address |
| done | output | 1 | One-cycle completion pulse |
| done_count | output | 16 | Bytes moved by the completed request |
| cur_ofs | output | 16 | Live current offset |
| cur_cnt | output | 17 | Live remaining count |

## Verification
The hardest case to reach is a reload that lands inside a request. The remaining count has to reach exactly zero partway through, and the buffer has to be short enough that the wrap happens more than once per request. The stimulus programs small base counts (a few bytes) and then asks for requests longer than the buffer. It also uses a request that drains the count exactly, so the reload is deferred to the first beat of the following request. Offsets just below 0xFFFF exercise the in-page wrap. A randomized phase then mixes touches, masks, zero-length requests and long requests against a behavioural reference model.

// File: rtl/dmae_pkg.sv
package dmae_pkg;
  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_t;
endpackage

// File: rtl/dmae_arm.sv
module dmae_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_touch,
  input  logic consume,
  output logic pending
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (consume)    pend_d = 1'b0;
    if (prog_touch) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b1;
    else        pend_q <= pend_d;
  end

  assign pending = pend_q;

  assert_touch_arms_R9: assert property (@(posedge clk) disable iff (!rst_n)
    prog_touch |=> pending);
  assert_consume_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !prog_touch) |=> !pending);
endmodule

// File: rtl/dmae_seq.sv
module dmae_seq #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [LEN_W-1:0] req_len,
  input  logic             chan_mask,
  output logic             req_ready,
  output logic             start,
  output logic             step,
  output logic             done,
  output logic [LEN_W-1:0] done_count
);
  import dmae_pkg::*;

  seq_state_t       state_q, state_d;
  logic [LEN_W-1:0] remain_q, remain_d;
  logic [LEN_W-1:0] moved_q, moved_d;
  logic             cnt_en;
  logic             done_q, done_d;
  logic [LEN_W-1:0] dcnt_q, dcnt_d;
  logic             accept, null_req, last;

  always_comb begin
    accept   = (state_q == SEQ_IDLE) && req_valid;
    null_req = accept && (chan_mask || (req_len == '0));
    start    = accept && !null_req;
    step     = (state_q == SEQ_RUN);
    last     = step && (remain_q == LEN_W'(1));

    state_d = state_q;
    if (start)     state_d = SEQ_RUN;
    else if (last) state_d = SEQ_IDLE;

    cnt_en   = start || step;
    remain_d = start ? req_len : remain_q - LEN_W'(1);
    moved_d  = start ? '0      : moved_q + LEN_W'(1);

    done_d = last || null_req;
    dcnt_d = dcnt_q;
    if (last)          dcnt_d = moved_q + LEN_W'(1);
    else if (null_req) dcnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      done_q  <= 1'b0;
      dcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      dcnt_q  <= dcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
      moved_q  <= '0;
    end else if (cnt_en) begin
      remain_q <= remain_d;
      moved_q  <= moved_d;
    end
  end

  assign req_ready  = (state_q == SEQ_IDLE);
  assign done       = done_q;
  assign done_count = dcnt_q;

  assert_no_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && remain_q != LEN_W'(1)) |=> step);
  assert_start_then_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> step);
  assert_done_follows_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_count != '0) |-> $past(step));
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done || $past(req_valid));
endmodule

// File: rtl/dmae_ptr.sv
module dmae_ptr #(
  parameter int OFS_W  = 16,
  parameter int PAGE_W = 8,
  localparam int CNT_W  = OFS_W + 1,
  localparam int PHYS_W = OFS_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [OFS_W-1:0]  base_ofs,
  input  logic [OFS_W-1:0]  base_cnt,
  input  logic [PAGE_W-1:0] page_in,
  output logic [OFS_W-1:0]  cur_ofs,
  output logic [CNT_W-1:0]  cur_cnt,
  output logic [PHYS_W-1:0] phys
);
  logic [OFS_W-1:0]  ofs_q, ofs_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PAGE_W-1:0] page_q, page_d;
  logic              empty, upd_en;
  logic [CNT_W-1:0]  full_len;

  always_comb begin
    empty    = (cnt_q == '0);
    full_len = {1'b0, base_cnt} + CNT_W'(1);
    upd_en   = load || step;
    phys     = empty ? {page_in, base_ofs} : {page_q, ofs_q};

    ofs_d  = ofs_q;
    cnt_d  = cnt_q;
    page_d = page_q;
    if (load) begin
      ofs_d  = base_ofs;
      cnt_d  = full_len;
      page_d = page_in;
    end else if (step) begin
      if (empty) begin
        ofs_d  = base_ofs + OFS_W'(1);
        cnt_d  = {1'b0, base_cnt};
        page_d = page_in;
      end else begin
        ofs_d  = ofs_q + OFS_W'(1);
        cnt_d  = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_q  <= '0;
      cnt_q  <= '0;
      page_q <= '0;
    end else if (upd_en) begin
      ofs_q  <= ofs_d;
      cnt_q  <= cnt_d;
      page_q <= page_d;
    end
  end

  assign cur_ofs = ofs_q;
  assign cur_cnt = cnt_q;

  assert_step_decrements_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cur_cnt != '0) |=> cur_cnt == $past(cur_cnt) - CNT_W'(1));
  assert_page_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cur_cnt != '0) |=> $stable(page_q));
  assert_reload_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cur_cnt == '0) |=> cur_cnt == {1'b0, $past(base_cnt)});
  assert_load_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cur_ofs == $past(base_ofs));
  assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(cur_ofs) && $stable(cur_cnt));
endmodule

// File: rtl/autoinit_dma_engine.sv
module autoinit_dma_engine #(
  parameter int OFS_W  = 16,
  parameter int PAGE_W = 8,
  parameter int LEN_W  = 16,
  localparam int CNT_W  = OFS_W + 1,
  localparam int PHYS_W = OFS_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFS_W-1:0]  cfg_base_ofs,
  input  logic [OFS_W-1:0]  cfg_base_cnt,
  input  logic [PAGE_W-1:0] cfg_page,
  input  logic              cfg_mask,
  input  logic              cfg_touch,
  input  logic              req_valid,
  input  logic [LEN_W-1:0]  req_len,
  output logic              req_ready,
  output logic              beat_valid,
  output logic [PHYS_W-1:0] beat_addr,
  output logic              done,
  output logic [LEN_W-1:0]  done_count,
  output logic [OFS_W-1:0]  cur_ofs,
  output logic [CNT_W-1:0]  cur_cnt
);
  logic pending, start, step, load;

  dmae_arm u_arm (
    .clk        (clk),
    .rst_n      (rst_n),
    .prog_touch (cfg_touch),
    .consume    (load),
    .pending    (pending)
  );

  dmae_seq #(.LEN_W(LEN_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_len    (req_len),
    .chan_mask  (cfg_mask),
    .req_ready  (req_ready),
    .start      (start),
    .step       (step),
    .done       (done),
    .done_count (done_count)
  );

  assign load = start && pending;

  dmae_ptr #(.OFS_W(OFS_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .step     (step),
    .base_ofs (cfg_base_ofs),
    .base_cnt (cfg_base_cnt),
    .page_in  (cfg_page),
    .cur_ofs  (cur_ofs),
    .cur_cnt  (cur_cnt),
    .phys     (beat_addr)
  );

  assign beat_valid = step;

  assert_null_request_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (cfg_mask || req_len == '0))
      |=> !beat_valid && done && done_count == '0);
  assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> !req_ready);
endmodule

// File: tb/autoinit_dma_engine_tb.sv
module autoinit_dma_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cfg_base_ofs, cfg_base_cnt, req_len;
  logic [7:0]  cfg_page;
  logic        cfg_mask, cfg_touch, req_valid;
  logic        req_ready, beat_valid, done;
  logic [23:0] beat_addr;
  logic [15:0] done_count, cur_ofs;
  logic [16:0] cur_cnt;

  int checks = 0;
  int errors = 0;
  int beats[$];

  // reference model state
  int  m_busy, m_rem, m_moved, m_addr, m_cnt, m_page, m_pend, m_done, m_dcnt;

  always #4 clk = ~clk;

  autoinit_dma_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_base_ofs(cfg_base_ofs), .cfg_base_cnt(cfg_base_cnt),
    .cfg_page(cfg_page), .cfg_mask(cfg_mask), .cfg_touch(cfg_touch),
    .req_valid(req_valid), .req_len(req_len), .req_ready(req_ready),
    .beat_valid(beat_valid), .beat_addr(beat_addr), .done(done),
    .done_count(done_count), .cur_ofs(cur_ofs), .cur_cnt(cur_cnt)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_rem = 0; m_moved = 0; m_addr = 0; m_cnt = 0;
      m_page = 0; m_pend = 1; m_done = 0; m_dcnt = 0;
    end else begin
      m_done = 0;
      if (m_busy != 0) begin
        if (m_cnt == 0) begin
          m_page = int'(cfg_page);
          m_addr = (int'(cfg_base_ofs) + 1) & 16'hFFFF;
          m_cnt  = int'(cfg_base_cnt);
        end else begin
          m_addr = (m_addr + 1) & 16'hFFFF;
          m_cnt  = m_cnt - 1;
        end
        m_moved++;
        m_rem--;
        if (m_rem == 0) begin
          m_busy = 0; m_done = 1; m_dcnt = m_moved;
        end
      end else if (req_valid) begin
        if (cfg_mask || req_len == 0) begin
          m_done = 1; m_dcnt = 0;
        end else begin
          if (m_pend != 0) begin
            m_addr = int'(cfg_base_ofs);
            m_cnt  = int'(cfg_base_cnt) + 1;
            m_page = int'(cfg_page);
            m_pend = 0;
          end
          m_busy = 1; m_rem = int'(req_len); m_moved = 0;
        end
      end
      if (cfg_touch) m_pend = 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int exp_phys;
      exp_phys = (m_cnt == 0) ? ((int'(cfg_page) << 16) | int'(cfg_base_ofs))
                              : ((m_page << 16) | m_addr);
      check(int'(beat_valid) == m_busy, "R5 beat_valid", int'(beat_valid), m_busy);
      check(int'(req_ready) == (m_busy == 0 ? 1 : 0), "R7 req_ready", int'(req_ready), int'(m_busy == 0));
      if (m_busy != 0) check(int'(beat_addr) == exp_phys, "R2 beat_addr", int'(beat_addr), exp_phys);
      check(int'(done) == m_done, "R7 done", int'(done), m_done);
      if (m_done != 0) check(int'(done_count) == m_dcnt, "R7 done_count", int'(done_count), m_dcnt);
      check(int'(cur_ofs) == m_addr, "R3 cur_ofs", int'(cur_ofs), m_addr);
      check(int'(cur_cnt) == m_cnt, "R6 cur_cnt", int'(cur_cnt), m_cnt);
      if (beat_valid) beats.push_back(int'(beat_addr));
    end
  end

  task automatic prog(input int b, input int c, input int p);
    @(negedge clk); #1;
    cfg_base_ofs = 16'(b); cfg_base_cnt = 16'(c); cfg_page = 8'(p); cfg_touch = 1'b1;
    @(negedge clk); #1;
    cfg_touch = 1'b0;
  endtask

  task automatic issue(input int len);
    @(negedge clk); #1;
    while (!req_ready) begin @(negedge clk); #1; end
    beats.delete();
    req_valid = 1'b1; req_len = 16'(len);
    @(negedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) begin @(negedge clk); #1; end
  endtask

  task automatic expect_beats(input string tag, input int exp[$]);
    check(beats.size() == exp.size(), {tag, " beat count"}, beats.size(), exp.size());
    for (int i = 0; i < exp.size() && i < beats.size(); i++)
      check(beats[i] == exp[i], {tag, " beat address"}, beats[i], exp[i]);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_base_ofs = '0; cfg_base_cnt = '0; cfg_page = '0;
    cfg_mask = 1'b0; cfg_touch = 1'b0; req_valid = 1'b0; req_len = '0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    check(req_ready && !beat_valid && !done, "R1 idle flags", int'({req_ready, beat_valid, done}), 3'b100);
    check(cur_ofs == 0 && cur_cnt == 0, "R1 pointers", int'(cur_cnt), 0);

    // R3 first request after touch loads base
    prog(16'h1000, 3, 8'h12);
    issue(2); wait_done();
    expect_beats("R3", '{24'h121000, 24'h121001});
    check(done_count == 2, "R7 count", int'(done_count), 2);
    check(cur_cnt == 2, "R3 leftover", int'(cur_cnt), 2);

    // R6 exhaustion mid-request reloads
    issue(5); wait_done();
    expect_beats("R6", '{24'h121002, 24'h121003, 24'h121000, 24'h121001, 24'h121002});
    check(cur_cnt == 1 && cur_ofs == 16'h1003, "R6 after reload", int'(cur_cnt), 1);

    // R4 masked and zero-length
    cfg_mask = 1'b1;
    issue(3); wait_done();
    check(done_count == 0 && beats.size() == 0, "R4 masked", int'(done_count), 0);
    cfg_mask = 1'b0;
    issue(0); wait_done();
    check(done_count == 0 && beats.size() == 0, "R4 zero length", beats.size(), 0);
    check(cur_ofs == 16'h1003 && cur_cnt == 1, "R4 unchanged", int'(cur_ofs), 16'h1003);

    // R8 wrap inside page
    prog(16'hFFFE, 9, 8'h05);
    issue(4); wait_done();
    expect_beats("R8", '{24'h05FFFE, 24'h05FFFF, 24'h050000, 24'h050001});

    // R6 exact drain then deferred reload
    prog(16'h0200, 1, 8'h33);
    issue(2); wait_done();
    check(cur_cnt == 0, "R6 drained", int'(cur_cnt), 0);
    issue(1); wait_done();
    expect_beats("R6 deferred", '{24'h330200});
    check(cur_cnt == 1, "R6 deferred count", int'(cur_cnt), 1);

    // R7 request while busy ignored
    prog(16'h4000, 16'h00FF, 8'h01);
    issue(10);
    req_valid = 1'b1; req_len = 16'd3;
    @(negedge clk); #1; req_valid = 1'b0;
    wait_done();
    check(done_count == 10, "R7 busy request ignored", int'(done_count), 10);
    repeat (3) @(negedge clk);
    #1 check(beats.size() == 10, "R7 no extra beats", beats.size(), 10);

    // R9 touch during a transfer
    issue(6);
    check(beats.size() >= 1 && beats[0] == 24'h01400A, "R9 running offset", beats[0], 24'h01400A);
    prog(16'h7000, 4, 8'h02);
    wait_done();
    check(beats.size() == 6 && beats[5] == 24'h01400F, "R9 old stream kept", beats[5], 24'h01400F);
    issue(1); wait_done();
    expect_beats("R9 new base", '{24'h027000});

    // R3 17-bit count
    prog(16'h0000, 16'hFFFF, 8'h00);
    issue(1); wait_done();
    check(cur_cnt == 17'h0FFFF, "R3 full length", int'(cur_cnt), 17'h0FFFF);

    // mixed stimulus against the model
    for (int k = 0; k < 40; k++) begin
      if ($urandom_range(0, 3) == 0) prog($urandom_range(16'hFFF0, 16'hFFFF), $urandom_range(0, 6), $urandom_range(0, 255));
      cfg_mask = ($urandom_range(0, 7) == 0);
      issue($urandom_range(0, 30)); wait_done();
      cfg_mask = 1'b0;
    end

    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule